// File: doc/BRIEF.md
# Real-to-Absolute Address Guard

This unit sits behind the address translator. It turns a real address into an absolute address by exchanging the lowest 8 KB of storage with the 8 KB block that starts at the per-CPU prefix value. In the same step it checks whether the access touches the two protected low areas. These are the first 512 bytes of page 0 and the first 512 bytes of page 1.

Protection depends on a control bit and, when translation is on, on the private-space bit of the address space that the access uses. The unit reports three things. The first is a permission vector. The second is a flag that stops the page from being kept in the TLB. The third is a protection fault for stores into a protected area. A protection fault carries a zero exception code. The access-register address-space mode is not supported and is reported on its own output.

Each request is taken with a valid/ready handshake. The result comes out of a single register stage.

Top module: `real_addr_guard`

## Requirements
- R1: A real address below 0x2000 maps to that address plus the prefix. Bits 12..0 of the prefix are ignored.
- R2: An address that is at or above the aligned prefix and less than prefix+0x2000 maps to that address minus the prefix. R1 takes priority over R2.
- R3: Any address not covered by R1 or R2 passes through unchanged.
- R4: Protection is enabled only when `in_lowprot_ctl` is 1. With translation off (`in_xlate_on`=0), that bit alone enables it. With translation on, the private-space bit of the selected space must also be 0. Space code 2'b00 (primary) uses `in_priv_pri`, 2'b10 (secondary) uses `in_priv_sec`, and 2'b11 (home) uses `in_priv_home`.
- R5: While protection is enabled, `out_tlb_inv` is 1 for every address below 0x2000, that is, for any address whose page is 0 or 1.
- R6: `out_prot_fault` is 1 only when protection is enabled, the access is a store, and the exact address is in 0..511 or 4096..4607. Access codes are 2'b00 fetch, 2'b01 read and 2'b10 store. Fetches and reads never fault.
- R7: With translation on, space code 2'b01 sets `out_unsup` and forces `out_perm`=0, `out_tlb_inv`=0 and `out_prot_fault`=0. With translation off, the space code has no effect.
- R8: `out_perm` has bit0 read, bit1 write and bit2 execute. Its value is 3'b111, except in the secondary space with translation on, where a fetch gives 3'b100 and a read or store gives 3'b011.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted request appears on the outputs with `out_valid`=1 one cycle later. The outputs hold steady while `out_valid`=1 and `out_ready`=0.
- R10: During reset, `out_valid` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | ADDR_W | Real address |
| in_acc | input | 2 | Access kind: 0 fetch, 1 read, 2 store |
| in_xlate_on | input | 1 | Dynamic translation enabled |
| in_space | input | 2 | Address-space mode: 0 primary, 1 access-register, 2 secondary, 3 home |
| in_lowprot_ctl | input | 1 | Low-area protection control bit |
| in_priv_pri | input | 1 | Private-space bit of primary designation |
| in_priv_sec | input | 1 | Private-space bit of secondary designation |
| in_priv_home | input | 1 | Private-space bit of home designation |
| in_prefix | input | ADDR_W | Prefix value (8 KB aligned) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer ready |
| out_abs_addr | output | ADDR_W | Absolute address |
| out_perm | output | 3 | Permission flags {exec, write, read} |
| out_tlb_inv | output | 1 | Do not retain this page in the TLB |
| out_prot_fault | output | 1 | Protection fault, exception code zero |
| out_unsup | output | 1 | Unsupported address-space mode |

## Verification
Every result (absolute address, permissions, TLB flag, fault and unsupported flag) becomes visible exactly one clock after the edge that accepts the request. The bench drives each request on a falling edge and lets one rising edge take it. It then reads the outputs on the following falling edge and compares them with its own model. Under backpressure, the bench checks that `in_ready` is low. It then checks at several falling edges that the held result does not change. Finally it checks that the waiting request appears exactly one edge after `out_ready` rises.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_STORE = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    SP_PRIMARY   = 2'b00,
    SP_ACCREG    = 2'b01,
    SP_SECONDARY = 2'b10,
    SP_HOME      = 2'b11
  } space_e;

  typedef struct packed {
    logic exec;
    logic write;
    logic read;
  } perm_t;
endpackage

// File: rtl/rag_prefix_swap.sv
module rag_prefix_swap #(
  parameter int ADDR_W    = 64,
  parameter int SWAP_BITS = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prefix,
  output logic [ADDR_W-1:0] abs_addr,
  output logic              low_hit,
  output logic              win_hit
);
  localparam logic [ADDR_W-1:0] SWAP_SIZE = ADDR_W'(1) << SWAP_BITS;

  function automatic logic [ADDR_W-1:0] align_prefix(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:SWAP_BITS], {SWAP_BITS{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] map_real(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] p);
    if (a < SWAP_SIZE)                   return a + p;
    else if (a >= p && (a - p) < SWAP_SIZE) return a - p;
    else                                 return a;
  endfunction

  logic [ADDR_W-1:0] pfx_al;

  always_comb begin
    pfx_al   = align_prefix(prefix);
    low_hit  = addr < SWAP_SIZE;
    win_hit  = !low_hit && addr >= pfx_al && (addr - pfx_al) < SWAP_SIZE;
    abs_addr = map_real(addr, pfx_al);
  end
endmodule

// File: rtl/rag_lowprot_check.sv
module rag_lowprot_check
  import rag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int PROT_BITS = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc,
  input  logic              xlate_on,
  input  logic [1:0]        space,
  input  logic              ctl_en,
  input  logic              priv_pri,
  input  logic              priv_sec,
  input  logic              priv_home,
  output logic              prot_on,
  output logic              unsup,
  output logic              tlb_inv,
  output logic              fault
);
  // page 0 or 1 of storage, regardless of the byte offset
  function automatic logic in_low_pages(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_BITS+1] == '0;
  endfunction

  // first 2**PROT_BITS bytes of page 0 or page 1
  function automatic logic in_prot_bytes(input logic [ADDR_W-1:0] a);
    return in_low_pages(a) && a[PAGE_BITS-1:PROT_BITS] == '0;
  endfunction

  logic priv_sel;

  always_comb begin
    unsup    = 1'b0;
    priv_sel = 1'b1;
    case (space_e'(space))
      SP_PRIMARY:   priv_sel = priv_pri;
      SP_SECONDARY: priv_sel = priv_sec;
      SP_HOME:      priv_sel = priv_home;
      default:      unsup    = xlate_on;
    endcase
    if (!xlate_on)  prot_on = ctl_en;
    else if (unsup) prot_on = 1'b0;
    else            prot_on = ctl_en && !priv_sel;
    tlb_inv = prot_on && in_low_pages(addr);
    fault   = prot_on && acc_e'(acc) == ACC_STORE && in_prot_bytes(addr);
  end
endmodule

// File: rtl/rag_perm_gen.sv
module rag_perm_gen
  import rag_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       xlate_on,
  input  logic [1:0] space,
  input  logic       unsup,
  output perm_t      perm
);
  always_comb begin
    perm = '{exec: 1'b1, write: 1'b1, read: 1'b1};
    if (unsup) begin
      perm = '0;
    end else if (xlate_on && space_e'(space) == SP_SECONDARY) begin
      if (acc_e'(acc) == ACC_FETCH) perm = '{exec: 1'b1, write: 1'b0, read: 1'b0};
      else                          perm = '{exec: 1'b0, write: 1'b1, read: 1'b1};
    end
  end
endmodule

// File: rtl/real_addr_guard.sv
module real_addr_guard
  import rag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int SWAP_BITS = 13,
  parameter int PAGE_BITS = 12,
  parameter int PROT_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_acc,
  input  logic              in_xlate_on,
  input  logic [1:0]        in_space,
  input  logic              in_lowprot_ctl,
  input  logic              in_priv_pri,
  input  logic              in_priv_sec,
  input  logic              in_priv_home,
  input  logic [ADDR_W-1:0] in_prefix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_abs_addr,
  output logic [2:0]        out_perm,
  output logic              out_tlb_inv,
  output logic              out_prot_fault,
  output logic              out_unsup
);
  localparam logic [ADDR_W-1:0] SWAP_SIZE = ADDR_W'(1) << SWAP_BITS;

  logic [ADDR_W-1:0] abs_w;
  logic              low_hit_w, win_hit_w;
  logic              prot_on_w, unsup_w, inv_w, fault_w;
  perm_t             perm_w;
  logic              take;

  rag_prefix_swap #(.ADDR_W(ADDR_W), .SWAP_BITS(SWAP_BITS)) u_swap (
    .addr(in_addr), .prefix(in_prefix), .abs_addr(abs_w),
    .low_hit(low_hit_w), .win_hit(win_hit_w)
  );

  rag_lowprot_check #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PROT_BITS(PROT_BITS)) u_prot (
    .addr(in_addr), .acc(in_acc), .xlate_on(in_xlate_on), .space(in_space),
    .ctl_en(in_lowprot_ctl), .priv_pri(in_priv_pri), .priv_sec(in_priv_sec),
    .priv_home(in_priv_home), .prot_on(prot_on_w), .unsup(unsup_w),
    .tlb_inv(inv_w), .fault(fault_w)
  );

  rag_perm_gen u_perm (
    .acc(in_acc), .xlate_on(in_xlate_on), .space(in_space),
    .unsup(unsup_w), .perm(perm_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_abs_addr   <= '0;
      out_perm       <= '0;
      out_tlb_inv    <= 1'b0;
      out_prot_fault <= 1'b0;
      out_unsup      <= 1'b0;
    end else if (take) begin
      out_valid      <= 1'b1;
      out_abs_addr   <= abs_w;
      out_perm       <= perm_w;
      out_tlb_inv    <= inv_w;
      out_prot_fault <= fault_w;
      out_unsup      <= unsup_w;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_abs_addr)
      && $stable(out_perm) && $stable(out_prot_fault) && $stable(out_tlb_inv));

  // R6
  fault_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && fault_w |-> in_acc == 2'b10 && prot_on_w);

  // R5
  fault_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prot_fault |-> out_tlb_inv);

  // R7
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> !out_prot_fault && !out_tlb_inv && out_perm == 3'b000);

  // R2
  win_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && win_hit_w |=> out_abs_addr < SWAP_SIZE);

  // R1
  low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && low_hit_w |=> out_abs_addr[SWAP_BITS-1:0] == $past(in_addr[SWAP_BITS-1:0]));
endmodule

// File: tb/real_addr_guard_tb.sv
module real_addr_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [1:0]  in_acc = '0;
  logic        in_xlate_on = 1'b0;
  logic [1:0]  in_space = '0;
  logic        in_lowprot_ctl = 1'b0;
  logic        in_priv_pri = 1'b0, in_priv_sec = 1'b0, in_priv_home = 1'b0;
  logic [63:0] in_prefix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_abs_addr;
  logic [2:0]  out_perm;
  logic        out_tlb_inv, out_prot_fault, out_unsup;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  real_addr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_acc(in_acc), .in_xlate_on(in_xlate_on),
    .in_space(in_space), .in_lowprot_ctl(in_lowprot_ctl),
    .in_priv_pri(in_priv_pri), .in_priv_sec(in_priv_sec), .in_priv_home(in_priv_home),
    .in_prefix(in_prefix), .out_valid(out_valid), .out_ready(out_ready),
    .out_abs_addr(out_abs_addr), .out_perm(out_perm), .out_tlb_inv(out_tlb_inv),
    .out_prot_fault(out_prot_fault), .out_unsup(out_unsup)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model
  function automatic logic [63:0] m_abs(input logic [63:0] a, input logic [63:0] p);
    logic [63:0] base = p & ~64'h1fff;
    if (a <= 64'h1fff) return a + base;
    if (a >= base && a <= base + 64'h1fff) return a - base;
    return a;
  endfunction
  function automatic logic m_unsup(input logic d, input logic [1:0] s);
    return d && s == 2'd1;
  endfunction
  function automatic logic m_en(input logic c, input logic d, input logic [1:0] s,
                                input logic pp, input logic ps, input logic ph);
    if (!c) return 1'b0;
    if (!d) return 1'b1;
    case (s)
      2'd0: return !pp;
      2'd2: return !ps;
      2'd3: return !ph;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic [2:0] m_perm(input logic d, input logic [1:0] s, input logic [1:0] acc);
    if (m_unsup(d, s)) return 3'b000;
    if (d && s == 2'd2) return (acc == 2'd0) ? 3'b100 : 3'b011;
    return 3'b111;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [1:0] acc, input logic d,
                       input logic [1:0] s, input logic c, input logic pp,
                       input logic ps, input logic ph, input logic [63:0] p);
    in_addr = a; in_acc = acc; in_xlate_on = d; in_space = s; in_lowprot_ctl = c;
    in_priv_pri = pp; in_priv_sec = ps; in_priv_home = ph; in_prefix = p;
  endtask

  task automatic check_cur(input string tag);
    logic en = m_en(in_lowprot_ctl, in_xlate_on, in_space, in_priv_pri, in_priv_sec, in_priv_home);
    logic [63:0] a = in_addr;
    chk({tag, " R9 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R1 R2 R3 addr"}, out_abs_addr, m_abs(a, in_prefix));
    chk({tag, " R8 perm"}, 64'(out_perm), 64'(m_perm(in_xlate_on, in_space, in_acc)));
    chk({tag, " R4 R5 inv"}, 64'(out_tlb_inv), 64'(en && a < 64'h2000));
    chk({tag, " R6 fault"}, 64'(out_prot_fault),
        64'(en && in_acc == 2'd2 && (a < 64'd512 || (a >= 64'd4096 && a < 64'd4608))));
    chk({tag, " R7 unsup"}, 64'(out_unsup), 64'(m_unsup(in_xlate_on, in_space)));
  endtask

  // one request, out_ready high: result due at the falling edge after the taking edge
  task automatic xact(input string tag, input logic [63:0] a, input logic [1:0] acc,
                      input logic d, input logic [1:0] s, input logic c, input logic pp,
                      input logic ps, input logic ph, input logic [63:0] p);
    @(negedge clk);
    drive(a, acc, d, s, c, pp, ps, ph, p);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_cur(tag);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] pfx;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R10 addr in reset", out_abs_addr, 64'd0);
    chk("R10 fault in reset", 64'(out_prot_fault), 64'd0);
    chk("R9 ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    pfx = 64'h0004_6000;
    // R1 low area mapping, prefix low bits ignored
    xact("R1 low", 64'h0000_0123, 2'd1, 1'b0, 2'd0, 1'b0, 0, 0, 0, pfx | 64'h0abc);
    chk("R1 exact", out_abs_addr, 64'h0004_6123);
    // R2 window mapping
    xact("R2 win", 64'h0004_7ffe, 2'd1, 1'b0, 2'd0, 1'b0, 0, 0, 0, pfx);
    chk("R2 exact", out_abs_addr, 64'h0000_1ffe);
    // R3 pass through just past window
    xact("R3 past", 64'h0004_8000, 2'd1, 1'b0, 2'd0, 1'b0, 0, 0, 0, pfx);
    chk("R3 exact", out_abs_addr, 64'h0004_8000);
    // R6 boundaries of the protected bytes, DAT off
    xact("R6 511", 64'd511, 2'd2, 1'b0, 2'd1, 1'b1, 1, 1, 1, pfx);
    chk("R6 511 fault", 64'(out_prot_fault), 64'd1);
    xact("R6 512", 64'd512, 2'd2, 1'b0, 2'd1, 1'b1, 1, 1, 1, pfx);
    chk("R6 512 no fault", 64'(out_prot_fault), 64'd0);
    chk("R5 512 inv", 64'(out_tlb_inv), 64'd1);
    xact("R6 4607", 64'd4607, 2'd2, 1'b0, 2'd0, 1'b1, 0, 0, 0, pfx);
    chk("R6 4607 fault", 64'(out_prot_fault), 64'd1);
    xact("R6 read", 64'd16, 2'd1, 1'b0, 2'd0, 1'b1, 0, 0, 0, pfx);
    chk("R6 read no fault", 64'(out_prot_fault), 64'd0);
    xact("R5 0x2000", 64'h2000, 2'd2, 1'b0, 2'd0, 1'b1, 0, 0, 0, pfx);
    chk("R5 0x2000 no inv", 64'(out_tlb_inv), 64'd0);
    // R4 private bit of the selected space
    xact("R4 home priv", 64'd8, 2'd2, 1'b1, 2'd3, 1'b1, 0, 0, 1, pfx);
    chk("R4 home priv off", 64'(out_prot_fault), 64'd0);
    xact("R4 sec clear", 64'd8, 2'd2, 1'b1, 2'd2, 1'b1, 1, 0, 1, pfx);
    chk("R4 sec on", 64'(out_prot_fault), 64'd1);
    // R7 access-register mode
    xact("R7 ar", 64'd8, 2'd2, 1'b1, 2'd1, 1'b1, 0, 0, 0, pfx);
    chk("R7 unsup", 64'(out_unsup), 64'd1);
    // R8 secondary fetch
    xact("R8 sfetch", 64'h9000, 2'd0, 1'b1, 2'd2, 1'b0, 0, 0, 0, pfx);
    chk("R8 fetch perm", 64'(out_perm), 64'd4);

    // R9 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h0000_0040, 2'd1, 1'b0, 2'd0, 1'b0, 0, 0, 0, pfx);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9 first held", out_abs_addr, 64'h0004_6040);
    drive(64'h0004_6080, 2'd1, 1'b0, 2'd0, 1'b0, 0, 0, 0, pfx);
    chk("R9 ready low", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 stable", out_abs_addr, 64'h0004_6040);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second", out_abs_addr, 64'h0000_0080);
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, p;
      int sel;
      p = {24'd0, $urandom, 8'd0} & ~64'h1fff;
      sel = int'($urandom_range(0, 3));
      case (sel)
        0: a = 64'($urandom_range(0, 32'h1fff));
        1: a = p + 64'($urandom_range(0, 32'h1fff));
        2: a = {$urandom, $urandom};
        default: a = 64'($urandom_range(0, 32'h3fff));
      endcase
      xact("rnd", a, 2'($urandom_range(0, 2)), 1'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), p);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule